// File: doc/BRIEF.md
# Prescaled PWM Time-Base Counter

This block produces the shared time base for a group of PWM output channels. A two-stage divider turns the input clock into a time-base tick. On each tick a 16-bit counter steps up, steps down, sweeps up and then down, or holds its value, as the control word selects. All channels share one period register. Period writes either land in a shadow copy or take effect at once, as the control word selects.

The counter value goes out to the downstream compare and action logic. Two strobes go with it: a zero-match event and a period-match event. A single write port loads either the control word or the period value.

Top module: `ptb_timebase`

## Requirements
- R1: After reset the counter reads 0, both strobes are low and the block is in hold mode (control word 0x0003). The counter stays at 0 until a new control word is written.
- R2: The tick divide is D = A * B. A is 1 when control[9:7] is 0 and 2*control[9:7] otherwise. B is 2 to the power of control[12:10]. A tick occurs once every D clocks, and the divider restarts from zero at every control write. Between ticks the counter does not change.
- R3: Up mode (control[1:0] = 00): on each tick the counter adds one. When the counter is at or above the period, the tick takes it to 0 instead.
- R4: Down mode (control[1:0] = 01): on each tick the counter subtracts one. When the counter is at 0, the tick loads the period.
- R5: Up-down mode (control[1:0] = 10): the counter counts 0, 1, ..., P, P-1, ..., 0, 1, and so on, turning at P and at 0. Every control write sets the direction back to upward.
- R6: Hold mode (control[1:0] = 11): the counter keeps its value, no strobe is raised and no shadow transfer takes place.
- R7: zero_evt is high for exactly one clock, in a clock cycle that ends with a tick while the counter is 0 and the mode is not hold. prd_evt follows the same rule for a counter equal to the active period.
- R8: With control[3] = 0 (shadowed), a period write changes only the shadow copy. The active period takes the shadow value at the tick that raises zero_evt, and the counter step at that same tick already uses the new value.
- R9: With control[3] = 1 (immediate), a period write changes the active period at the edge that accepts the write.
- R10: A write with wr_sel = 0 loads the control word; a write with wr_sel = 1 loads the period. Either one takes effect at the edge where wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data | input | 16 | Write data |
| tb_cnt | output | 16 | Current time-base counter value |
| zero_evt | output | 1 | Zero-match strobe |
| prd_evt | output | 1 | Period-match strobe |

## Verification
The bench writes a shadowed period in the middle of a count. A design that transfers the shadow at the wrong moment would cut the running period short, or would leave the old period in place for one extra cycle. It measures the clock distance between counter steps for a mixed divider setting. A wrong factor formula, such as treating the high-speed field as a power of two, gives a different spacing. Immediate period writes below the current count, zero periods, and up-down sweeps are exercised along with random configurations. These catch a counter that runs past its period, a count that never turns, a strobe that stays high for more than one clock, and a strobe raised in hold mode.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   typedef enum logic [1:0] {
      MODE_UP   = 2'b00,
      MODE_DOWN = 2'b01,
      MODE_UPDN = 2'b10,
      MODE_HOLD = 2'b11
   } ptb_mode_e;

   localparam int MODE_LSB  = 0;
   localparam int PLOAD_BIT = 3;
   localparam int HS_LSB    = 7;
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
   parameter int HS_W = 3,
   parameter int CK_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [HS_W-1:0] hs_sel,
   input  logic [CK_W-1:0] ck_sel,
   output logic            tick
);
   localparam int DIV_W = HS_W + (1 << CK_W);

   logic [HS_W:0]    hs_fac;
   logic [DIV_W-1:0] div_fac;
   logic [DIV_W-1:0] pre_q;

   initial begin
      assert (HS_W >= 1 && CK_W >= 1 && CK_W <= 4)
         else $error("ptb_prescaler: divider field widths out of range");
   end

   always_comb begin
      hs_fac  = (hs_sel == '0) ? (HS_W+1)'(1) : {hs_sel, 1'b0};
      div_fac = DIV_W'(hs_fac) << ck_sel;
      tick    = (pre_q >= (div_fac - DIV_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (tick)    pre_q <= '0;
      else              pre_q <= pre_q + DIV_W'(1);
   end

   a_r2_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_q == '0));
endmodule

// File: rtl/ptb_period.sv
module ptb_period #(
   parameter int CW        = 16,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   input  logic          imm,
   input  logic          load,
   output logic [CW-1:0] act_prd,
   output logic [CW-1:0] next_prd
);
   generate
      if (SHADOW_EN) begin : g_shadow
         logic [CW-1:0] shd_q;
         logic [CW-1:0] act_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shd_q <= '0;
               act_q <= '0;
            end else begin
               if (wr) shd_q <= wdata;
               if (wr && imm) act_q <= wdata;
               else if (load) act_q <= shd_q;
            end
         end

         assign act_prd  = act_q;
         assign next_prd = load ? shd_q : act_q;

         a_r8_shadow_xfer: assert property (@(posedge clk) disable iff (!rst_n)
            (load && !wr) |=> (act_prd == $past(shd_q)));
         a_r8_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !imm && !load) |=> $stable(act_prd));
      end else begin : g_direct
         logic [CW-1:0] act_q;
         logic          unused_ok;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  act_q <= '0;
            else if (wr) act_q <= wdata;
         end

         assign act_prd   = act_q;
         assign next_prd  = act_q;
         assign unused_ok = ^{imm, load};
      end
   endgenerate

   a_r9_imm_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && imm) |=> (act_prd == $past(wdata)));
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
   import ptb_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  ptb_mode_e     mode,
   input  logic          restart,
   input  logic [CW-1:0] next_prd,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] cnt_q, cnt_d;
   logic          up_q, up_d;

   always_comb begin
      cnt_d = cnt_q;
      up_d  = up_q;
      if (tick) begin
         unique case (mode)
            MODE_UP:   cnt_d = (cnt_q >= next_prd) ? '0 : cnt_q + CW'(1);
            MODE_DOWN: cnt_d = (cnt_q == '0) ? next_prd : cnt_q - CW'(1);
            MODE_UPDN: begin
               if (up_q) begin
                  if (cnt_q >= next_prd) begin
                     up_d  = 1'b0;
                     cnt_d = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
                  end else begin
                     cnt_d = cnt_q + CW'(1);
                  end
               end else begin
                  if (cnt_q == '0) begin
                     up_d  = 1'b1;
                     cnt_d = (next_prd == '0) ? '0 : CW'(1);
                  end else begin
                     cnt_d = cnt_q - CW'(1);
                  end
               end
            end
            default:   cnt_d = cnt_q;
         endcase
      end
      if (restart) up_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

   assign cnt = cnt_q;

   a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UP && cnt_q != '0 && cnt_q < next_prd)
      |=> (cnt == $past(cnt) + CW'(1)));
   a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_DOWN && cnt_q != '0) |=> (cnt == $past(cnt) - CW'(1)));
   a_r5_updn_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UPDN && !up_q && cnt_q != '0)
      |=> (cnt == $past(cnt) - CW'(1)));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD) |=> $stable(cnt));
endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase
   import ptb_pkg::*;
#(
   parameter int CW        = 16,
   parameter int HS_W      = 3,
   parameter int CK_W      = 3,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] tb_cnt,
   output logic          zero_evt,
   output logic          prd_evt
);
   localparam int CK_LSB = HS_LSB + HS_W;

   ptb_mode_e     mode_q;
   logic          imm_q;
   logic [HS_W-1:0] hs_q;
   logic [CK_W-1:0] ck_q;
   logic          ctrl_wr, prd_wr, tick, load;
   logic [CW-1:0] act_prd, next_prd;

   initial begin
      assert (CK_LSB + CK_W <= CW && HS_LSB > PLOAD_BIT)
         else $error("ptb_timebase: control fields do not fit the data width");
   end

   assign ctrl_wr = wr_en && !wr_sel;
   assign prd_wr  = wr_en && wr_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_HOLD;
         imm_q  <= 1'b0;
         hs_q   <= '0;
         ck_q   <= '0;
      end else if (ctrl_wr) begin
         mode_q <= ptb_mode_e'(wr_data[MODE_LSB +: 2]);
         imm_q  <= wr_data[PLOAD_BIT];
         hs_q   <= wr_data[HS_LSB +: HS_W];
         ck_q   <= wr_data[CK_LSB +: CK_W];
      end
   end

   ptb_prescaler #(.HS_W(HS_W), .CK_W(CK_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr),
      .hs_sel(hs_q), .ck_sel(ck_q), .tick(tick)
   );

   assign load = tick && (mode_q != MODE_HOLD) && (tb_cnt == '0) && !imm_q;

   ptb_period #(.CW(CW), .SHADOW_EN(SHADOW_EN)) u_prd (
      .clk(clk), .rst_n(rst_n), .wr(prd_wr), .wdata(wr_data),
      .imm(imm_q), .load(load), .act_prd(act_prd), .next_prd(next_prd)
   );

   ptb_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
      .restart(ctrl_wr), .next_prd(next_prd), .cnt(tb_cnt)
   );

   assign zero_evt = tick && (mode_q != MODE_HOLD) && (tb_cnt == '0);
   assign prd_evt  = tick && (mode_q != MODE_HOLD) && (tb_cnt == act_prd);

   a_r2_no_step_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tb_cnt));
   a_r7_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && (mode_q == MODE_UP || mode_q == MODE_DOWN) && act_prd != '0 && !wr_en)
      |=> !zero_evt);
endmodule

// File: tb/ptb_timebase_tb.sv
`timescale 1ns/1ps
module ptb_timebase_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] tb_cnt;
   logic        zero_evt, prd_evt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ptb_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tb_cnt(tb_cnt), .zero_evt(zero_evt), .prd_evt(prd_evt)
   );

   // reference model built from the requirements
   logic [15:0] m_ctrl, m_act, m_shd, m_cnt;
   logic        m_up;
   int          m_pre;

   function automatic int div_of(logic [15:0] c);
      int a;
      a = (c[9:7] == 0) ? 1 : 2 * int'(c[9:7]);
      return a * (1 << c[12:10]);
   endfunction

   function automatic bit m_tick();
      return m_pre >= div_of(m_ctrl) - 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= 16'h0003; m_act <= 0; m_shd <= 0; m_cnt <= 0; m_up <= 1; m_pre <= 0;
      end else begin
         bit t, ld, cw, pw;
         logic [15:0] np, nc;
         logic nu;
         t  = m_tick();
         ld = t && m_ctrl[1:0] != 2'b11 && m_cnt == 0 && !m_ctrl[3];
         cw = wr_en && !wr_sel;
         pw = wr_en && wr_sel;
         np = ld ? m_shd : m_act;
         nc = m_cnt; nu = m_up;
         if (t) begin
            case (m_ctrl[1:0])
               2'b00: nc = (m_cnt >= np) ? 16'd0 : m_cnt + 16'd1;
               2'b01: nc = (m_cnt == 0) ? np : m_cnt - 16'd1;
               2'b10: begin
                  if (m_up) begin
                     if (m_cnt >= np) begin nu = 0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
                     else nc = m_cnt + 16'd1;
                  end else begin
                     if (m_cnt == 0) begin nu = 1; nc = (np == 0) ? 16'd0 : 16'd1; end
                     else nc = m_cnt - 16'd1;
                  end
               end
               default: nc = m_cnt;
            endcase
         end
         if (cw) nu = 1;
         m_cnt <= nc; m_up <= nu;
         m_pre <= (cw || t) ? 0 : m_pre + 1;
         if (pw) m_shd <= wr_data;
         if (pw && m_ctrl[3]) m_act <= wr_data;
         else if (ld) m_act <= m_shd;
         if (cw) m_ctrl <= wr_data;
      end
   end

   function automatic string mode_tag(logic [1:0] m);
      case (m)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cmp_model();
      bit t;
      t = m_tick();
      check(mode_tag(m_ctrl[1:0]), "counter", int'(tb_cnt), int'(m_cnt));
      check("R7", "zero_evt", int'(zero_evt),
            int'(t && m_ctrl[1:0] != 2'b11 && m_cnt == 0));
      check("R7", "prd_evt", int'(prd_evt),
            int'(t && m_ctrl[1:0] != 2'b11 && m_cnt == m_act));
   endtask

   task automatic cyc();
      @(negedge clk);
      cmp_model();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr(bit sel, logic [15:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      cyc();
      wr_en = 0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      int gap, mx;
      logic [15:0] c0;
      #12 rst_n = 1;
      @(negedge clk);
      // R1: reset state, hold mode keeps the counter at 0
      check("R1", "reset cnt", int'(tb_cnt), 0);
      check("R1", "reset zero_evt", int'(zero_evt), 0);
      check("R1", "reset prd_evt", int'(prd_evt), 0);
      run(5);
      check("R1", "hold after reset", int'(tb_cnt), 0);

      // R9 / R10: immediate period write, then up mode
      wr(0, 16'h000B);            // hold, immediate
      wr(1, 16'd3);
      run(3);
      check("R10", "control write keeps hold", int'(tb_cnt), 0);
      wr(0, 16'h0008);            // up, immediate, div 1
      run(20);
      wr(0, 16'h0009);            // R4 down
      run(20);
      wr(0, 16'h000A);            // R5 up-down
      run(20);
      wr(1, 16'd0);               // zero period corner
      run(8);
      wr(1, 16'd3);

      // R2: divider spacing with A=6, B=2 -> 12 clocks
      wr(1, 16'd10);
      wr(0, 16'h0588);
      c0 = tb_cnt; gap = 0;
      while (tb_cnt == c0 && gap < 100) begin cyc(); gap++; end
      check("R2", "clocks between ticks", gap, 12);
      c0 = tb_cnt; gap = 0;
      while (tb_cnt == c0 && gap < 100) begin cyc(); gap++; end
      check("R2", "second tick spacing", gap, 12);

      // R9: immediate write below running count wraps on next tick
      wr(0, 16'h0008);
      while (tb_cnt != 5) cyc();
      wr(1, 16'd2);
      check("R9", "step with old period", int'(tb_cnt), 6);
      cyc();
      check("R9", "wrap after immediate write", int'(tb_cnt), 0);
      wr(1, 16'd3);
      while (tb_cnt != 0) cyc();

      // R8: shadowed period write takes effect after zero
      wr(0, 16'h0000);            // up, shadow, div 1
      while (tb_cnt != 1) cyc();
      wr(1, 16'd6);
      mx = 0;
      while (tb_cnt != 0) begin if (tb_cnt > mx) mx = tb_cnt; cyc(); end
      check("R8", "old period kept until zero", mx, 3);
      run(6);
      check("R8", "new period after zero", int'(tb_cnt), 6);

      // R6: hold mid-count, shadow write not transferred
      wr(0, 16'h0003);
      c0 = tb_cnt;
      wr(1, 16'd2);
      run(10);
      check("R6", "hold keeps counter", int'(tb_cnt), int'(c0));

      // random mix
      void'($urandom(32'h5A17));
      for (int r = 0; r < 25; r++) begin
         logic [15:0] cw;
         cw = 16'($urandom_range(0, 3)) | (16'($urandom_range(0, 1)) << 3) |
              (16'($urandom_range(0, 3)) << 7) | (16'($urandom_range(0, 1)) << 10);
         wr(1, 16'($urandom_range(0, 15)));
         wr(0, cw);
         for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 7) == 0) wr(1, 16'($urandom_range(0, 15)));
            else cyc();
         end
      end
      finish_up();
   end
endmodule